// File: doc/BRIEF.md
# DMA Page Translation Unit

This block turns the logical addresses issued by a DMA engine into physical memory addresses. Logical space is cut into 4096-byte pages. Each logical page has one 8-byte entry in a translation table kept in system memory. Software places that table with a base register and bounds it with a limit register. Within each entry, the 32-bit word at the entry's start holds the physical frame address.

A request carries a 24-bit logical address. The unit first checks that the page's entry lies inside the table. It then looks the page up in a four-entry fully associative translation cache. On a miss it reads the entry word through a valid/ready memory read port and stalls the request until that read completes. Its response is the physical address of the frame with the page offset attached, or a fault.

A write to the invalidate register flushes the cache. Two readable capture registers hold the most recent out-of-table logical address and the most recent failing entry address.

Top module: `dma_xlate_unit`

## Requirements
- R1: A good response's `rsp_paddr` is bits 28..12 of the entry word in bits 28..12, and logical address bits 11..0 in bits 11..0. Entry word bits 11..0 have no effect.
- R2: On a miss, exactly one memory read is issued, at address `base + page_index*8`, where page_index is logical address bits 23..12.
- R3: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and all four configuration read selects return 0. The reset limit of 0 puts every page out of range.
- R4: A request whose page is cached gets its response in the cycle after acceptance, and no memory read is issued.
- R5: Writing select 2 (data ignored) flushes every cached page, so the next lookup of any page reads memory. A read still outstanding when the write lands delivers its response but is not installed.
- R6: If page_index*8 >= limit, the response faults with `rsp_paddr` 0, no memory read is issued, and the logical address is captured in read select 2. page_index*8 = limit-8 is in range.
- R7: The cache holds four pages. When full, it replaces them in the order they were filled.
- R8: `mem_req_valid` stays high with a constant `mem_req_addr` until `mem_req_ready`. A response is taken only after the request handshake.
- R9: A memory read with `mem_rsp_err`, or an entry word with any of bits 31..29 set, gives a fault with `rsp_paddr` 0. The entry address is captured in read select 3, and the page is not cached.
- R10: Each accepted request produces exactly one single-cycle `rsp_valid` pulse, and `req_ready` stays low until it has been produced.
- R11: Configuration select 0 is the table base and select 1 the table limit. Both can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Write select: 0 base, 1 limit, 2 invalidate |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 2 | Read select: 0 base, 1 limit, 2 range-fail address, 3 memory-fail address |
| cfg_rd_data | output | 32 | Read data (combinational) |
| req_valid | input | 1 | Translation request |
| req_laddr | input | 24 | Logical address |
| req_ready | output | 1 | Unit can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 29 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | 32 | Byte address of the entry word |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| mem_rsp_err | input | 1 | Read failed |

## Verification
A stale cache entry shows up at the ports as a missing memory read and an old frame. The bench catches it on the first lookup after an invalidate, and on the lookup after an eviction. A wrong replacement pointer evicts the wrong page, and that shows as an unexpected hit or miss within one or two requests. A broken range compare shows up at once: either a memory read appears for an out-of-table page, or the page faults at exactly limit-8. A stalled or doubled response appears as a wrong cycle count between acceptance and `rsp_valid`.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_FETCH = 2'd2,
      ST_WAIT  = 2'd3
   } dxu_state_e;

   localparam logic [1:0] SEL_BASE  = 2'd0;
   localparam logic [1:0] SEL_LIMIT = 2'd1;
   localparam logic [1:0] SEL_INV   = 2'd2;  // write: flush
   localparam logic [1:0] SEL_XFAIL = 2'd2;  // read: range fail address
   localparam logic [1:0] SEL_MFAIL = 2'd3;  // read: memory fail address
endpackage

// File: rtl/dxu_regs.sv
module dxu_regs
   import dxu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LA_W   = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] base_o,
   output logic [DATA_W-1:0] limit_o,
   output logic              inv_o,
   input  logic              xfail_set,
   input  logic [LA_W-1:0]   xfail_addr,
   input  logic              mfail_set,
   input  logic [DATA_W-1:0] mfail_addr
);
   logic [DATA_W-1:0] base_q, limit_q, mfail_q;
   logic [LA_W-1:0]   xfail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
         xfail_q <= '0;
         mfail_q <= '0;
      end else begin
         if (wr_en && wr_sel == SEL_BASE)  base_q  <= wr_data;
         if (wr_en && wr_sel == SEL_LIMIT) limit_q <= wr_data;
         if (xfail_set) xfail_q <= xfail_addr;
         if (mfail_set) mfail_q <= mfail_addr;
      end
   end

   assign inv_o   = wr_en && (wr_sel == SEL_INV);
   assign base_o  = base_q;
   assign limit_o = limit_q;

   always_comb begin
      unique case (rd_sel)
         SEL_BASE:  rd_data = base_q;
         SEL_LIMIT: rd_data = limit_q;
         SEL_XFAIL: rd_data = DATA_W'(xfail_q);
         default:   rd_data = mfail_q;
      endcase
   end
endmodule

// File: rtl/dxu_tcache.sv
module dxu_tcache #(
   parameter int TAG_W = 12,
   parameter int DAT_W = 17,
   parameter int WAYS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [TAG_W-1:0] lk_tag,
   output logic [WAYS-1:0]  hit_vec,
   output logic             lk_hit,
   output logic [DAT_W-1:0] lk_data,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [DAT_W-1:0] fill_data
);
   localparam int PTR_W = $clog2(WAYS);

   logic [WAYS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [WAYS];
   logic [DAT_W-1:0] dat_q [WAYS];
   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
         for (int w = 0; w < WAYS; w++) begin
            tag_q[w] <= '0;
            dat_q[w] <= '0;
         end
      end else if (flush) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (fill_en) begin
         vld_q[ptr_q] <= 1'b1;
         tag_q[ptr_q] <= fill_tag;
         dat_q[ptr_q] <= fill_data;
         ptr_q        <= PTR_W'(ptr_q + 1'b1);
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_vec[w] = vld_q[w] && (tag_q[w] == lk_tag);
   end

   always_comb begin
      lk_data = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) lk_data = lk_data | dat_q[w];
   end

   assign lk_hit = |hit_vec;
endmodule

// File: rtl/dxu_ctrl.sv
module dxu_ctrl
   import dxu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int LA_W        = 24,
   parameter int PA_W        = 29,
   parameter int PAGE_SHIFT  = 12,
   parameter int ENTRY_SHIFT = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [LA_W-1:0]            req_laddr,
   output logic                       req_ready,
   output logic                       rsp_valid,
   output logic [PA_W-1:0]            rsp_paddr,
   output logic                       rsp_fault,
   input  logic [DATA_W-1:0]          base,
   input  logic [DATA_W-1:0]          limit,
   input  logic                       inv,
   output logic [LA_W-PAGE_SHIFT-1:0] lk_tag,
   input  logic                       lk_hit,
   input  logic [PA_W-PAGE_SHIFT-1:0] lk_data,
   output logic                       fill_en,
   output logic [LA_W-PAGE_SHIFT-1:0] fill_tag,
   output logic [PA_W-PAGE_SHIFT-1:0] fill_data,
   output logic                       mem_req_valid,
   output logic [DATA_W-1:0]          mem_req_addr,
   input  logic                       mem_req_ready,
   input  logic                       mem_rsp_valid,
   input  logic [DATA_W-1:0]          mem_rsp_data,
   input  logic                       mem_rsp_err,
   output logic                       xfail_set,
   output logic [LA_W-1:0]            xfail_addr,
   output logic                       mfail_set,
   output logic [DATA_W-1:0]          mfail_addr
);
   localparam int LIDX_W = LA_W - PAGE_SHIFT;
   localparam int FRM_W  = PA_W - PAGE_SHIFT;

   dxu_state_e        state_q;
   logic [LA_W-1:0]   laddr_q;
   logic [DATA_W-1:0] addr_q;
   logic              stale_q;

   logic [LIDX_W-1:0]     idx;
   logic [PAGE_SHIFT-1:0] pofs;
   logic [DATA_W-1:0]     ent_ofs, ent_addr;
   logic                  out_of_range, hit_eff, hi_clear, frame_ok;
   logic [FRM_W-1:0]      mem_frame;
   logic                  unused_low;

   assign idx      = laddr_q[LA_W-1:PAGE_SHIFT];
   assign pofs     = laddr_q[PAGE_SHIFT-1:0];
   assign ent_ofs  = DATA_W'({idx, {ENTRY_SHIFT{1'b0}}});
   assign ent_addr = base + ent_ofs;
   assign out_of_range = (ent_ofs >= limit);
   assign hit_eff  = lk_hit && !inv;

   // Frame bits above the physical range make the entry unusable.
   if (PA_W < DATA_W) begin : g_hi_chk
      assign hi_clear = ~|mem_rsp_data[DATA_W-1:PA_W];
   end else begin : g_hi_none
      assign hi_clear = 1'b1;
   end

   assign mem_frame  = mem_rsp_data[PA_W-1:PAGE_SHIFT];
   assign unused_low = ^mem_rsp_data[PAGE_SHIFT-1:0];
   assign frame_ok   = !mem_rsp_err && hi_clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         laddr_q   <= '0;
         addr_q    <= '0;
         stale_q   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               laddr_q <= req_laddr;
               stale_q <= 1'b0;
               state_q <= ST_CHECK;
            end
            ST_CHECK: begin
               if (out_of_range) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b1;
                  rsp_paddr <= '0;
                  state_q   <= ST_IDLE;
               end else if (hit_eff) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_paddr <= {lk_data, pofs};
                  state_q   <= ST_IDLE;
               end else begin
                  addr_q  <= ent_addr;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (inv) stale_q <= 1'b1;
               if (mem_req_ready) state_q <= ST_WAIT;
            end
            default: begin
               if (inv) stale_q <= 1'b1;
               if (mem_rsp_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= !frame_ok;
                  rsp_paddr <= frame_ok ? {mem_frame, pofs} : '0;
                  state_q   <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign lk_tag        = idx;
   assign mem_req_valid = (state_q == ST_FETCH);
   assign mem_req_addr  = addr_q;

   assign fill_en   = (state_q == ST_WAIT) && mem_rsp_valid && frame_ok && !stale_q && !inv;
   assign fill_tag  = idx;
   assign fill_data = mem_frame;

   assign xfail_set  = (state_q == ST_CHECK) && out_of_range;
   assign xfail_addr = laddr_q;
   assign mfail_set  = (state_q == ST_WAIT) && mem_rsp_valid && !frame_ok;
   assign mfail_addr = addr_q;
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit #(
   parameter int DATA_W      = 32,
   parameter int LA_W        = 24,
   parameter int PA_W        = 29,
   parameter int PAGE_SHIFT  = 12,
   parameter int ENTRY_SHIFT = 3,
   parameter int WAYS        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [1:0]        cfg_wr_sel,
   input  logic [DATA_W-1:0] cfg_wr_data,
   input  logic [1:0]        cfg_rd_sel,
   output logic [DATA_W-1:0] cfg_rd_data,
   input  logic              req_valid,
   input  logic [LA_W-1:0]   req_laddr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault,
   output logic              mem_req_valid,
   output logic [DATA_W-1:0] mem_req_addr,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic              mem_rsp_err
);
   localparam int LIDX_W = LA_W - PAGE_SHIFT;
   localparam int FRM_W  = PA_W - PAGE_SHIFT;

   if (PA_W > DATA_W || PA_W <= PAGE_SHIFT) begin : g_bad_pa
      $error("PA_W must lie in (PAGE_SHIFT, DATA_W]");
   end
   if (LA_W <= PAGE_SHIFT || LIDX_W + ENTRY_SHIFT > DATA_W) begin : g_bad_la
      $error("LA_W does not fit the page and entry geometry");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] tbl_base, tbl_limit, mfail_addr;
   logic              inv_pulse, xfail_set, mfail_set;
   logic [LA_W-1:0]   xfail_addr;
   logic [LIDX_W-1:0] lk_tag, fill_tag;
   logic [FRM_W-1:0]  lk_data, fill_data;
   logic              lk_hit, fill_en;
   logic [WAYS-1:0]   hit_vec;

   dxu_regs #(.DATA_W(DATA_W), .LA_W(LA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
      .rd_sel(cfg_rd_sel), .rd_data(cfg_rd_data),
      .base_o(tbl_base), .limit_o(tbl_limit), .inv_o(inv_pulse),
      .xfail_set(xfail_set), .xfail_addr(xfail_addr),
      .mfail_set(mfail_set), .mfail_addr(mfail_addr)
   );

   dxu_tcache #(.TAG_W(LIDX_W), .DAT_W(FRM_W), .WAYS(WAYS)) u_cache (
      .clk(clk), .rst_n(rst_n), .flush(inv_pulse),
      .lk_tag(lk_tag), .hit_vec(hit_vec), .lk_hit(lk_hit), .lk_data(lk_data),
      .fill_en(fill_en), .fill_tag(fill_tag), .fill_data(fill_data)
   );

   dxu_ctrl #(
      .DATA_W(DATA_W), .LA_W(LA_W), .PA_W(PA_W),
      .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_laddr(req_laddr), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .base(tbl_base), .limit(tbl_limit), .inv(inv_pulse),
      .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
      .fill_en(fill_en), .fill_tag(fill_tag), .fill_data(fill_data),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .xfail_set(xfail_set), .xfail_addr(xfail_addr),
      .mfail_set(mfail_set), .mfail_addr(mfail_addr)
   );
endmodule

// File: rtl/dxu_xlate_chk.sv
module dxu_xlate_chk #(
   parameter int DATA_W     = 32,
   parameter int PA_W       = 29,
   parameter int PAGE_SHIFT = 12,
   parameter int WAYS       = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic [PAGE_SHIFT-1:0] req_ofs,
   input logic                  rsp_valid,
   input logic                  rsp_fault,
   input logic [PA_W-1:0]       rsp_paddr,
   input logic                  mem_req_valid,
   input logic                  mem_req_ready,
   input logic [DATA_W-1:0]     mem_req_addr,
   input logic [DATA_W-1:0]     tbl_base,
   input logic [DATA_W-1:0]     tbl_limit,
   input logic                  inv_pulse,
   input logic [WAYS-1:0]       hit_vec
);
   logic [PAGE_SHIFT-1:0] ofs_q;
   always_ff @(posedge clk) begin
      if (!rst_n) ofs_q <= '0;
      else if (req_valid && req_ready) ofs_q <= req_ofs;
   end

   // R1: page offset of the accepted request reaches the response
   p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_paddr[PAGE_SHIFT-1:0] == ofs_q);

   // R5: a flush leaves no cached page matching in the next cycle
   p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      inv_pulse |=> hit_vec == '0);

   // R6: a table read never targets an entry outside the table
   p_read_in_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) && $stable(tbl_base) && $stable(tbl_limit)
      |-> (mem_req_addr - tbl_base) < tbl_limit);

   // R7: a page is held in at most one cache entry
   p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R8: pending read holds its address
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R9: a fault carries a zero address
   p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_paddr == '0);

   // R10: response strobe lasts one cycle and blocks new requests
   p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
endmodule

bind dma_xlate_unit dxu_xlate_chk #(
   .DATA_W(DATA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .WAYS(WAYS)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready), .req_ofs(req_laddr[PAGE_SHIFT-1:0]),
   .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
   .inv_pulse(inv_pulse), .hit_vec(hit_vec)
);

// File: tb/sim_dma_xlate_unit.sv
`timescale 1ns/1ps
module sim_dma_xlate_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [1:0]  cfg_wr_sel = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [1:0]  cfg_rd_sel = '0;
   logic [31:0] cfg_rd_data;
   logic        req_valid = 1'b0;
   logic [23:0] req_laddr = '0;
   logic        req_ready, rsp_valid, rsp_fault;
   logic [28:0] rsp_paddr;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;

   int n_checks = 0, n_errors = 0;
   int n_mem = 0, mem_lat = 0, stall_n = 0, stall_left = 0;
   logic [31:0] tb_base = 32'h0010_0000;
   logic [31:0] hs_addr = '0;

   localparam logic [11:0] POISON_IDX = 12'h040;
   localparam logic [11:0] ERR_IDX    = 12'h041;

   always #5 clk = ~clk;

   dma_xlate_unit u0 (.*);

   function automatic logic [31:0] mword(logic [11:0] i);
      logic [31:0] w;
      w = {3'b000, i[4:0] ^ 5'h11, i ^ 12'hC3A, 12'hFFF};
      if (i == POISON_IDX) w[31] = 1'b1;
      return w;
   endfunction

   function automatic logic [28:0] exp_pa(logic [23:0] la);
      logic [31:0] w;
      w = mword(la[23:12]);
      return {w[28:12], la[11:0]};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: one read outstanding, fixed latency, optional ready stall
   initial begin
      logic pend;
      int cnt;
      pend = 1'b0;
      cnt = 0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_rsp_err   = 1'b0;
         if (pend) begin
            if (cnt == 0) begin
               logic [11:0] i;
               i = 12'((hs_addr - tb_base) >> 3);
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = mword(i);
               mem_rsp_err   = (i == ERR_IDX);
               pend = 1'b0;
            end else cnt--;
         end
         if (mem_req_valid) begin
            if (stall_left > 0) begin
               mem_req_ready = 1'b0;
               stall_left--;
            end else begin
               mem_req_ready = 1'b1;
               pend = 1'b1;
               cnt = mem_lat;
               hs_addr = mem_req_addr;
               n_mem++;
               stall_left = stall_n;
            end
         end else mem_req_ready = 1'b0;
      end
   end

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
      cfg_rd_sel = sel;
      #1 d = cfg_rd_data;
   endtask

   task automatic xlate(input logic [23:0] la, output logic [28:0] pa, output logic flt, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_laddr = la;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 0;
      while (!rsp_valid && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      pa = rsp_paddr; flt = rsp_fault;
      @(negedge clk);
      check(!rsp_valid, "R10 single pulse", {31'd0, rsp_valid}, 32'd0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check(req_ready == 1'b1, "R3 req_ready", {31'd0, req_ready}, 32'd1);
      check(!rsp_valid && !mem_req_valid, "R3 idle outputs", {30'd0, rsp_valid, mem_req_valid}, 32'd0);
      for (int s = 0; s < 4; s++) begin
         reg_read(2'(s), d);
         check(d == 32'd0, "R3 register reset", d, 32'd0);
      end
   endtask

   task automatic t_config();
      logic [31:0] d;
      reg_write(2'd0, tb_base);
      reg_write(2'd1, 32'h8000);
      reg_read(2'd0, d);
      check(d == tb_base, "R11 base readback", d, tb_base);
      reg_read(2'd1, d);
      check(d == 32'h8000, "R11 limit readback", d, 32'h8000);
   endtask

   task automatic t_miss_hit();
      logic [28:0] pa; logic f; int lat, m0;
      m0 = n_mem;
      xlate(24'h003ABC, pa, f, lat);
      check(!f && pa == exp_pa(24'h003ABC), "R1 miss result", {3'b0, pa}, {3'b0, exp_pa(24'h003ABC)});
      check(n_mem == m0 + 1, "R2 one read on miss", n_mem, m0 + 1);
      check(hs_addr == tb_base + 32'h18, "R2 entry address", hs_addr, tb_base + 32'h18);
      m0 = n_mem;
      xlate(24'h003001, pa, f, lat);
      check(!f && pa == exp_pa(24'h003001), "R4 hit result", {3'b0, pa}, {3'b0, exp_pa(24'h003001)});
      check(n_mem == m0, "R4 no read on hit", n_mem, m0);
      check(lat == 1, "R4 hit latency", lat, 1);
   endtask

   task automatic t_round_robin();
      logic [28:0] pa; logic f; int lat, m0;
      xlate(24'h00A010, pa, f, lat);
      xlate(24'h00B020, pa, f, lat);
      xlate(24'h00C030, pa, f, lat);
      xlate(24'h00D040, pa, f, lat);   // evicts page 3
      m0 = n_mem;
      xlate(24'h003FFF, pa, f, lat);   // evicts page A
      check(n_mem == m0 + 1, "R7 oldest evicted", n_mem, m0 + 1);
      check(pa == exp_pa(24'h003FFF), "R1 refetch result", {3'b0, pa}, {3'b0, exp_pa(24'h003FFF)});
      m0 = n_mem;
      xlate(24'h00B777, pa, f, lat);
      check(n_mem == m0, "R7 third fill kept", n_mem, m0);
      xlate(24'h00A111, pa, f, lat);
      check(n_mem == m0 + 1, "R7 second fill evicted", n_mem, m0 + 1);
   endtask

   task automatic t_invalidate();
      logic [28:0] pa; logic f; int lat, m0;
      reg_write(2'd2, 32'hDEAD_BEEF);
      m0 = n_mem;
      xlate(24'h00C222, pa, f, lat);
      check(n_mem == m0 + 1, "R5 refetch after flush", n_mem, m0 + 1);
      xlate(24'h00C223, pa, f, lat);
      check(n_mem == m0 + 1 && pa == exp_pa(24'h00C223), "R5 refill hits", n_mem, m0 + 1);
   endtask

   task automatic t_range();
      logic [28:0] pa; logic f; int lat, m0; logic [31:0] d;
      reg_write(2'd1, 32'h100);
      m0 = n_mem;
      xlate(24'h01F456, pa, f, lat);
      check(!f && pa == exp_pa(24'h01F456), "R6 last entry in range", {3'b0, pa}, {3'b0, exp_pa(24'h01F456)});
      check(n_mem == m0 + 1, "R6 last entry read", n_mem, m0 + 1);
      m0 = n_mem;
      xlate(24'h020123, pa, f, lat);
      check(f && pa == 29'd0, "R6 out of range fault", {2'b0, f, pa}, {2'b0, 1'b1, 29'd0});
      check(n_mem == m0, "R6 no read when out of range", n_mem, m0);
      reg_read(2'd2, d);
      check(d == 32'h0002_0123, "R6 range fail capture", d, 32'h0002_0123);
      reg_write(2'd1, 32'h8000);
   endtask

   task automatic t_mem_fault();
      logic [28:0] pa; logic f; int lat, m0; logic [31:0] d;
      xlate(24'h040777, pa, f, lat);
      check(f && pa == 29'd0, "R9 high frame bits fault", {2'b0, f, pa}, {2'b0, 1'b1, 29'd0});
      reg_read(2'd3, d);
      check(d == tb_base + 32'h200, "R9 fail capture", d, tb_base + 32'h200);
      m0 = n_mem;
      xlate(24'h040778, pa, f, lat);
      check(f && n_mem == m0 + 1, "R9 fault not cached", n_mem, m0 + 1);
      xlate(24'h041000, pa, f, lat);
      check(f && pa == 29'd0, "R9 read error fault", {2'b0, f, pa}, {2'b0, 1'b1, 29'd0});
      reg_read(2'd3, d);
      check(d == tb_base + 32'h208, "R9 error capture", d, tb_base + 32'h208);
   endtask

   task automatic t_backpressure();
      logic [28:0] pa; logic f; int lat, m0;
      stall_n = 3; stall_left = 3; mem_lat = 2;
      m0 = n_mem;
      xlate(24'h060ABC, pa, f, lat);
      check(!f && pa == exp_pa(24'h060ABC), "R8 result under stall", {3'b0, pa}, {3'b0, exp_pa(24'h060ABC)});
      check(n_mem == m0 + 1, "R8 single handshake", n_mem, m0 + 1);
      check(lat == 8, "R8 stalled latency", lat, 8);
      stall_n = 0; stall_left = 0; mem_lat = 0;
   endtask

   task automatic t_stale_fill();
      logic [28:0] pa; logic f; int lat, m0;
      mem_lat = 8;
      fork
         xlate(24'h050321, pa, f, lat);
         begin
            repeat (5) @(negedge clk);
            reg_write(2'd2, 32'd0);
         end
      join
      mem_lat = 0;
      check(!f && pa == exp_pa(24'h050321), "R5 outstanding read delivered", {3'b0, pa}, {3'b0, exp_pa(24'h050321)});
      m0 = n_mem;
      xlate(24'h050322, pa, f, lat);
      check(n_mem == m0 + 1, "R5 outstanding read not cached", n_mem, m0 + 1);
   endtask

   initial begin
      #2_000_000;
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", n_checks);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_config();
      t_miss_hit();
      t_round_robin();
      t_invalidate();
      t_range();
      t_mem_fault();
      t_backpressure();
      t_stale_fill();
      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule